// File: doc/BRIEF.md
# Operand Shifter with Rotate-Through-Carry

This block shifts the second operand of a 32-bit datapath before it reaches the ALU. It supports three operations: a logical left shift, a logical right shift, and a one-bit rotate to the right that passes through the carry flag. It also produces a shifter carry-out. The ALU writes that carry-out into its C flag when an instruction asks for flags to be set, and ignores it otherwise.

The block has no clock and no state. A two-bit type input picks the operation. An eight-bit amount sets the distance, and the current carry flag is applied to the zero-distance and rotate cases. The allowed range of amounts differs by direction: a left shift reaches 31 places and a right shift reaches 32. If an amount is larger than its direction allows, it is reduced to that direction's limit and an error output is raised. Internally, a decoder turns the type and amount into a few select strobes and a clamped distance, and two barrel networks compute the two shift directions.

Top module: `op_shifter`

## Requirements
- R1: With type 2'b00 (left) and an amount n from 1 to 31, the result is the operand shifted left by n places, and the low n bits are zero.
- R2: With type 2'b00 and an amount n from 1 to 31, carry-out equals operand bit (32-n).
- R3: With type 2'b01 (right) and an amount n from 1 to 31, the result is the operand shifted right by n places with zeros in the top n bits, and carry-out equals operand bit (n-1).
- R4: With type 2'b01 and an amount of 32, the result is all zeros and carry-out equals operand bit 31.
- R5: With type 2'b00 or 2'b01 and an amount of 0, the result equals the operand and carry-out equals the carry input.
- R6: With type 2'b10 (rotate through carry), the result is the operand shifted right by one with the carry input in bit 31, and carry-out equals operand bit 0. The amount input has no effect on either output.
- R7: Type 2'b11 is reserved. It passes the operand through unchanged, and carry-out equals the carry input.
- R8: With type 2'b00, an amount above 31 acts as 31. With type 2'b01, an amount above 32 acts as 32. In both cases the error output is 1. In every other case, including types 2'b10 and 2'b11 with any amount, the error output is 0.
- R9: The outputs are a pure function of the present inputs. A new input value is reflected in the same clock period, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 32 | Operand to shift |
| shiftType | input | 2 | 00 left, 01 right, 10 rotate through carry, 11 reserved |
| shiftAmt | input | 8 | Requested shift distance |
| carryIn | input | 1 | Present carry flag |
| resultOut | output | 32 | Shifted operand |
| carryOut | output | 1 | Shifter carry-out for the C flag |
| rangeErr | output | 1 | Amount was clamped to its direction's limit |

## Verification
Each operation is driven with walking-one operands, which show the exact bit position that reaches the result and the carry. Alternating patterns and all-ones operands expose any wrong fill value. Amounts are swept over 0, 1, 31, 32 and values above the range, which separates the pass-through, normal, full-width and clamp paths and shows that the two directions have different limits. Random operands, amounts and carry values then run against a bit-by-bit model, and the carry input is toggled so that a rotate or a zero-distance shift which ignores it is caught.

// File: rtl/op_shifter_pkg.sv
package op_shifter_pkg;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_RRX   = 2'b10,
    SH_RSVD  = 2'b11
  } shType_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic selLeft;
    logic selRight;
    logic selRrx;
    logic amtZero;
  } shCtl_t;

endpackage

// File: rtl/op_shifter_ctl.sv
module op_shifter_ctl
  import op_shifter_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AMT_IN_W = 8,
  localparam int unsigned AMT_W   = $clog2(DATA_W) + 1
) (
  input  logic [1:0]          shiftType,
  input  logic [AMT_IN_W-1:0] shiftAmt,
  output shCtl_t              ctl,
  output logic [AMT_W-1:0]    effAmt,
  output logic                rangeErr
);

  localparam logic [AMT_IN_W-1:0] LEFT_MAX  = AMT_IN_W'(DATA_W - 1);
  localparam logic [AMT_IN_W-1:0] RIGHT_MAX = AMT_IN_W'(DATA_W);

  shType_e typ;
  logic    tooFarLeft;
  logic    tooFarRight;

  always_comb begin
    typ         = shType_e'(shiftType);
    tooFarLeft  = (typ == SH_LEFT)  && (shiftAmt > LEFT_MAX);
    tooFarRight = (typ == SH_RIGHT) && (shiftAmt > RIGHT_MAX);
    rangeErr    = tooFarLeft || tooFarRight;

    if (tooFarLeft)       effAmt = AMT_W'(LEFT_MAX);
    else if (tooFarRight) effAmt = AMT_W'(RIGHT_MAX);
    else                  effAmt = shiftAmt[AMT_W-1:0];

    ctl.selLeft  = (typ == SH_LEFT);
    ctl.selRight = (typ == SH_RIGHT);
    ctl.selRrx   = (typ == SH_RRX);
    ctl.amtZero  = (shiftAmt == '0);
  end

  // Clamped distance never exceeds the direction limit (R8)
  always_comb begin
    if (ctl.selLeft)
      p_clamp_left_r8: assert (effAmt <= AMT_W'(DATA_W - 1));
    if (ctl.selRight)
      p_clamp_right_r8: assert (effAmt <= AMT_W'(DATA_W));
    if (ctl.selRrx || !(ctl.selLeft || ctl.selRight))
      p_no_err_other_r8: assert (!rangeErr);
    p_onehot_sel_r7: assert ($onehot0({ctl.selLeft, ctl.selRight, ctl.selRrx}));
  end

endmodule

// File: rtl/op_shifter_dp.sv
module op_shifter_dp
  import op_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] opIn,
  input  logic              carryIn,
  input  shCtl_t            ctl,
  input  logic [AMT_W-1:0]  effAmt,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);

  // Extended by one bit so the last bit shifted out lands in a fixed place
  logic [DATA_W:0] leftNet;
  logic [DATA_W:0] rightNet;

  always_comb begin
    leftNet  = {1'b0, opIn};
    rightNet = {opIn, 1'b0};
    for (int k = 0; k < AMT_W; k++) begin
      if (effAmt[k]) begin
        leftNet  = leftNet  << (1 << k);
        rightNet = rightNet >> (1 << k);
      end
    end
  end

  always_comb begin
    if (ctl.selRrx) begin
      resultOut = {carryIn, opIn[DATA_W-1:1]};
      carryOut  = opIn[0];
    end else if (ctl.amtZero || !(ctl.selLeft || ctl.selRight)) begin
      resultOut = opIn;
      carryOut  = carryIn;
    end else if (ctl.selLeft) begin
      resultOut = leftNet[DATA_W-1:0];
      carryOut  = leftNet[DATA_W];
    end else begin
      resultOut = rightNet[DATA_W:1];
      carryOut  = rightNet[0];
    end
  end

  // Output-side properties guarding the selection above
  always_comb begin
    if (ctl.selRrx) begin
      p_rrx_top_r6: assert (resultOut[DATA_W-1] == carryIn);
      p_rrx_carry_r6: assert (carryOut == opIn[0]);
    end
    if ((ctl.selLeft || ctl.selRight) && ctl.amtZero)
      p_zero_pass_r5: assert (resultOut == opIn && carryOut == carryIn);
    if (ctl.selLeft && !ctl.amtZero)
      p_left_fill_r1: assert ((resultOut & ((DATA_W'(1) << effAmt) - DATA_W'(1))) == '0);
    if (ctl.selRight && effAmt == AMT_W'(DATA_W) && !ctl.amtZero)
      p_right_full_r4: assert (resultOut == '0 && carryOut == opIn[DATA_W-1]);
  end

endmodule

// File: rtl/op_shifter.sv
module op_shifter
  import op_shifter_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AMT_IN_W = 8,
  localparam int unsigned AMT_W   = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0]   opIn,
  input  logic [1:0]          shiftType,
  input  logic [AMT_IN_W-1:0] shiftAmt,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   resultOut,
  output logic                carryOut,
  output logic                rangeErr
);

  shCtl_t           ctl;
  logic [AMT_W-1:0] effAmt;

  op_shifter_ctl #(.DATA_W(DATA_W), .AMT_IN_W(AMT_IN_W)) uCtl (
    .shiftType (shiftType),
    .shiftAmt  (shiftAmt),
    .ctl       (ctl),
    .effAmt    (effAmt),
    .rangeErr  (rangeErr)
  );

  op_shifter_dp #(.DATA_W(DATA_W)) uDp (
    .opIn      (opIn),
    .carryIn   (carryIn),
    .ctl       (ctl),
    .effAmt    (effAmt),
    .resultOut (resultOut),
    .carryOut  (carryOut)
  );

endmodule

// File: tb/op_shifter_test.sv
`timescale 1ns/1ps
module op_shifter_test;

  logic        clk = 1'b0;
  logic [31:0] opIn = '0;
  logic [1:0]  shiftType = '0;
  logic [7:0]  shiftAmt = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;
  logic        rangeErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  op_shifter uut (
    .opIn(opIn), .shiftType(shiftType), .shiftAmt(shiftAmt), .carryIn(carryIn),
    .resultOut(resultOut), .carryOut(carryOut), .rangeErr(rangeErr)
  );

  // Behavioural reference, bit by bit
  task automatic refModel(input logic [31:0] op, input logic [1:0] t, input logic [7:0] a,
                          input logic c, output logic [31:0] r, output logic co, output logic e);
    int n;
    n = a; e = 0; r = op; co = c;
    case (t)
      2'b00: begin
        if (n > 31) begin n = 31; e = 1; end
        if (n != 0) begin
          for (int i = 0; i < 32; i++) r[i] = (i >= n) ? op[i-n] : 1'b0;
          co = op[32-n];
        end
      end
      2'b01: begin
        if (n > 32) begin n = 32; e = 1; end
        if (n != 0) begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : 1'b0;
          co = op[n-1];
        end
      end
      2'b10: begin
        for (int i = 0; i < 31; i++) r[i] = op[i+1];
        r[31] = c; co = op[0];
      end
      default: ;
    endcase
  endtask

  function automatic string tagFor(input logic [1:0] t, input logic [7:0] a);
    if (t == 2'b10) return "R6";
    if (t == 2'b11) return "R7";
    if (a == 0) return "R5";
    if (t == 2'b00) return (a > 31) ? "R8" : "R1/R2";
    if (a == 32) return "R4";
    return (a > 32) ? "R8" : "R3";
  endfunction

  task automatic applyAndCheck(input logic [31:0] op, input logic [1:0] t, input logic [7:0] a,
                               input logic c, input string tag);
    logic [31:0] er; logic ec, ee;
    @(posedge clk);
    opIn = op; shiftType = t; shiftAmt = a; carryIn = c;
    refModel(op, t, a, c, er, ec, ee);
    @(negedge clk);
    testsRun++;
    if (resultOut !== er || carryOut !== ec || rangeErr !== ee) begin
      testsFailed++;
      $display("FAIL %s: op=%h type=%b amt=%0d cin=%b actual res=%h c=%b err=%b expected res=%h c=%b err=%b",
               tag, op, t, a, c, resultOut, carryOut, rangeErr, er, ec, ee);
    end
  endtask

  initial begin
    // Initial state: all-zero inputs give all-zero outputs
    @(negedge clk);
    testsRun++;
    if (resultOut !== '0 || carryOut !== 1'b0 || rangeErr !== 1'b0) begin
      testsFailed++;
      $display("FAIL R5 initial: actual res=%h c=%b err=%b expected 0 0 0", resultOut, carryOut, rangeErr);
    end
    // R1 R2 walking one left
    for (int n = 1; n < 32; n++) applyAndCheck(32'h1 << (32 - n), 2'b00, 8'(n), 1'b0, "R2");
    applyAndCheck(32'hFFFF_FFFF, 2'b00, 8'd31, 1'b0, "R1");
    applyAndCheck(32'hA5A5_5A5A, 2'b00, 8'd1, 1'b1, "R1");
    // R3 walking one right
    for (int n = 1; n < 32; n++) applyAndCheck(32'h1 << (n - 1), 2'b01, 8'(n), 1'b0, "R3");
    applyAndCheck(32'hFFFF_FFFF, 2'b01, 8'd31, 1'b0, "R3");
    // R4 full-width right
    applyAndCheck(32'h8000_0000, 2'b01, 8'd32, 1'b0, "R4");
    applyAndCheck(32'h7FFF_FFFF, 2'b01, 8'd32, 1'b1, "R4");
    // R5 zero distance keeps carry
    applyAndCheck(32'hDEAD_BEEF, 2'b00, 8'd0, 1'b1, "R5");
    applyAndCheck(32'hDEAD_BEEF, 2'b01, 8'd0, 1'b0, "R5");
    applyAndCheck(32'h1234_5678, 2'b01, 8'd0, 1'b1, "R5");
    // R6 rotate through carry, amount ignored
    applyAndCheck(32'h0000_0001, 2'b10, 8'd0, 1'b1, "R6");
    applyAndCheck(32'h0000_0001, 2'b10, 8'd200, 1'b0, "R6");
    applyAndCheck(32'hFFFF_FFFE, 2'b10, 8'd5, 1'b1, "R6");
    // R7 reserved passes through
    applyAndCheck(32'hCAFE_F00D, 2'b11, 8'd7, 1'b1, "R7");
    applyAndCheck(32'hCAFE_F00D, 2'b11, 8'd255, 1'b0, "R7");
    // R8 clamp and error
    applyAndCheck(32'h0000_0003, 2'b00, 8'd32, 1'b0, "R8");
    applyAndCheck(32'h0000_0003, 2'b00, 8'd255, 1'b1, "R8");
    applyAndCheck(32'h8000_0001, 2'b01, 8'd33, 1'b0, "R8");
    applyAndCheck(32'h8000_0001, 2'b01, 8'd128, 1'b0, "R8");
    // R9 consecutive changes seen in the same period
    applyAndCheck(32'h0F0F_0F0F, 2'b00, 8'd4, 1'b0, "R9");
    applyAndCheck(32'hF0F0_F0F0, 2'b01, 8'd4, 1'b1, "R9");
    // Random sweep
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] op; logic [1:0] t; logic [7:0] a; logic c;
      op = $urandom; t = 2'($urandom); c = 1'($urandom);
      a = (i % 3 == 0) ? 8'($urandom) : 8'($urandom_range(0, 33));
      applyAndCheck(op, t, a, c, tagFor(t, a));
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule